// File: doc/BRIEF.md
# Camera Serial Packet Decoder

This block sits behind the lane-alignment stage of a camera serial receiver. It takes one aligned byte per accepted cycle, with a marker on the first byte of every packet. It collects the four header bytes, checks the header's error-correcting code and classifies the packet by its 6-bit data type. Synchronisation short packets drive one-cycle frame and line pulses and a frame-level qualifier. Long packets stream their payload bytes out with a per-byte line-valid strobe until the word count runs out. The two checksum bytes after the payload are swallowed.

A frame/line state machine follows the expected order: frame start, optional line start, image lines, optional line end, frame end. Explicit line markers are honoured when the sensor sends them. When a long packet arrives with no line open, line pulses are made from its first and last payload bytes. The two virtual-channel bits of the identifier byte are ignored. Gaps between accepted bytes are allowed anywhere.

Top module: `csi_packet_decoder`

## Requirements
- R1: A packet begins with a byte accepted with `in_sop` high. Header bytes arrive in this order: identifier (data type in bits 5:0, virtual channel in bits 7:6), word count low byte, word count high byte, check byte. The check byte must equal {2'b00, P5..P0}. Each Pk is the even parity of a fixed subset of the 24 header bits {wc_hi, wc_lo, id}, using the standard 6-bit Hamming column codes of the camera serial interface.
- R2: When the check byte mismatches, `ecc_err` is high for the one cycle after the check byte. That packet then makes no pulse and no `line_valid`, and it leaves `data_type` and `word_count` unchanged.
- R3: Data type 0x00 pulses `frame_start` for one cycle, in the cycle after the check byte, and `frame_valid` is high from that cycle on. A frame start inside an open frame restarts the frame.
- R4: Data type 0x01 inside a frame pulses `frame_end` for one cycle. `frame_valid` is still high in that cycle and low in the next one.
- R5: A frame end received while no frame is open is ignored: no pulse, and `frame_valid` stays low.
- R6: Data type 0x02 pulses `line_start` only inside a frame with no line open, and opens a line. Data type 0x03 pulses `line_end` only when a line is open, and closes it. Either packet in any other state is ignored.
- R7: A long packet (data type 0x10 or above) with a non-zero word count N, received inside a frame, outputs exactly N payload bytes on `pix_byte`. Each byte appears with `line_valid` high in the cycle after it is accepted. The two checksum bytes that follow are never output.
- R8: When a long packet starts while no line is open, `line_start` pulses together with its first output byte and `line_end` pulses together with its last. When a line was opened by data type 0x02, the payload makes no line pulses.
- R9: A long packet received outside a frame produces no `line_valid`.
- R10: For every header that passes the check, `data_type` becomes {2'b00, id[5:0]} and `word_count` becomes the 16-bit field, in the cycle after the check byte. Because the virtual-channel bits are ignored, identifier 0x40 acts as a frame start and 0xC1 acts as a frame end.
- R11: After reset all outputs are zero.
- R12: Short data types 0x04 to 0x0F make no pulse and leave the frame/line state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_sop | input | 1 | Accepted byte is the first header byte of a packet |
| in_byte | input | 8 | Aligned lane byte |
| frame_start | output | 1 | One-cycle frame start pulse |
| frame_end | output | 1 | One-cycle frame end pulse |
| line_start | output | 1 | One-cycle line start pulse |
| line_end | output | 1 | One-cycle line end pulse |
| frame_valid | output | 1 | High from frame start through frame end |
| line_valid | output | 1 | `pix_byte` holds a payload byte this cycle |
| pix_byte | output | 8 | Payload byte |
| word_count | output | 16 | Word count of the last good header |
| data_type | output | 8 | Data type of the last good header |
| ecc_err | output | 1 | One-cycle header check mismatch flag |

## Verification
A table of short packets is walked through every frame/line state. Repeated line starts and line ends, a frame end with no frame, generic short types, identifiers with virtual-channel bits set, and a corrupted check byte separate the legal transitions from the ones that must be ignored. Long packets are sent in three situations: with no line open, inside an explicit line, and outside any frame. These show the difference between derived line pulses and explicit ones, and that payload is suppressed outside a frame. A corrupted long header followed by body bytes confirms that a rejected packet leaves no trace on the outputs. The checksum bytes are checked to never reach `pix_byte`.

// File: rtl/csi_dec_pkg.sv
// Shared constants and types for the camera packet decoder.
// Assumes 8-bit lane bytes and a 4-byte packet header.
package csi_dec_pkg;
    localparam int BYTE_W    = 8;
    localparam int WC_W      = 16;
    localparam int DT_W      = 6;
    localparam int ECC_W     = 6;
    localparam int HDR_BYTES = 4;
    localparam int HDR_W     = BYTE_W * (HDR_BYTES - 1);

    // Row masks: parity bit k covers the header bits set in row k.
    localparam logic [ECC_W-1:0][HDR_W-1:0] ECC_ROWS = {
        24'hEFFC00, 24'hDF03F0, 24'hB8E38E,
        24'h749A6D, 24'hF2555B, 24'hF12CB7
    };

    localparam logic [DT_W-1:0] DT_FRM_BEGIN = 6'h00;
    localparam logic [DT_W-1:0] DT_FRM_CLOSE = 6'h01;
    localparam logic [DT_W-1:0] DT_LN_BEGIN  = 6'h02;
    localparam logic [DT_W-1:0] DT_LN_CLOSE  = 6'h03;
    localparam logic [DT_W-1:0] DT_LONG_MIN  = 6'h10;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_OPEN = 2'd1,
        FR_LINE = 2'd2
    } frame_st_t;
endpackage

// File: rtl/csi_ecc_gen.sv
// Combinational 6-bit header check generator.
// Assumes the 24 covered bits are {wc_hi, wc_lo, identifier}.
module csi_ecc_gen
    import csi_dec_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_bits,
    output logic [ECC_W-1:0] ecc_calc
);
    // One parity tree per check bit.
    for (genvar k = 0; k < ECC_W; k++) begin : g_par
        assign ecc_calc[k] = ^(hdr_bits & ECC_ROWS[k]);
    end
endmodule

// File: rtl/csi_hdr_capture.sv
// Collects the first three header bytes and flags the check byte.
// Assumes in_sop marks the identifier byte; an in_sop restarts capture.
module csi_hdr_capture
    import csi_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              hdr_done,
    output logic [HDR_W-1:0]  hdr_bits,
    output logic [BYTE_W-1:0] ecc_rx,
    output logic              body_vld,
    output logic [BYTE_W-1:0] body_byte
);
    localparam int CNT_W = $clog2(HDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);

    logic [CNT_W-1:0]                  idx_q;
    logic [HDR_BYTES-2:0][BYTE_W-1:0]  store_q;

    // Byte index within the header; zero means no header in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            store_q <= '0;
        end else if (in_valid) begin
            if (in_sop) begin
                store_q[0] <= in_byte;
                idx_q      <= CNT_W'(1);
            end else if (idx_q == LAST_IDX) begin
                idx_q <= '0;
            end else if (idx_q != '0) begin
                store_q[idx_q] <= in_byte;
                idx_q          <= idx_q + CNT_W'(1);
            end
        end
    end

    // Header completion and body byte qualification.
    always_comb begin
        hdr_done  = in_valid && !in_sop && (idx_q == LAST_IDX);
        hdr_bits  = store_q;
        ecc_rx    = in_byte;
        body_vld  = in_valid && !in_sop && (idx_q == '0);
        body_byte = in_byte;
    end
endmodule

// File: rtl/csi_frame_fsm.sv
// Frame/line sequencer and payload streamer.
// Assumes hdr_done/ecc_ok are valid in the cycle the check byte arrives.
module csi_frame_fsm
    import csi_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_done,
    input  logic [HDR_W-1:0]  hdr_bits,
    input  logic              ecc_ok,
    input  logic              body_vld,
    input  logic [BYTE_W-1:0] body_byte,
    output logic              frame_start,
    output logic              frame_end,
    output logic              line_start,
    output logic              line_end,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [BYTE_W-1:0] pix_byte,
    output logic [WC_W-1:0]   word_count,
    output logic [BYTE_W-1:0] data_type,
    output logic              ecc_err
);
    frame_st_t       fst_q;
    logic            in_pay_q;
    logic            first_q;
    logic            auto_q;
    logic [WC_W-1:0] rem_q;
    logic [DT_W-1:0] dt;
    logic [WC_W-1:0] wc;

    // Header field split.
    always_comb begin
        dt = hdr_bits[DT_W-1:0];
        wc = hdr_bits[HDR_W-1:BYTE_W];
    end

    // Sequencing of sync packets, payload counting and all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst_q       <= FR_IDLE;
            in_pay_q    <= 1'b0;
            first_q     <= 1'b0;
            auto_q      <= 1'b0;
            rem_q       <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            line_start  <= 1'b0;
            line_end    <= 1'b0;
            frame_valid <= 1'b0;
            line_valid  <= 1'b0;
            pix_byte    <= '0;
            word_count  <= '0;
            data_type   <= '0;
            ecc_err     <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            line_start  <= 1'b0;
            line_end    <= 1'b0;
            line_valid  <= 1'b0;
            ecc_err     <= 1'b0;
            if (frame_end) frame_valid <= 1'b0;
            if (hdr_done) begin
                in_pay_q <= 1'b0;
                if (!ecc_ok) begin
                    ecc_err <= 1'b1;
                end else begin
                    data_type  <= BYTE_W'(dt);
                    word_count <= wc;
                    if (dt == DT_FRM_BEGIN) begin
                        frame_start <= 1'b1;
                        frame_valid <= 1'b1;
                        fst_q       <= FR_OPEN;
                    end else if (dt == DT_FRM_CLOSE) begin
                        if (fst_q != FR_IDLE) begin
                            frame_end <= 1'b1;
                            fst_q     <= FR_IDLE;
                        end
                    end else if (dt == DT_LN_BEGIN) begin
                        if (fst_q == FR_OPEN) begin
                            line_start <= 1'b1;
                            fst_q      <= FR_LINE;
                        end
                    end else if (dt == DT_LN_CLOSE) begin
                        if (fst_q == FR_LINE) begin
                            line_end <= 1'b1;
                            fst_q    <= FR_OPEN;
                        end
                    end else if (dt >= DT_LONG_MIN && fst_q != FR_IDLE && wc != '0) begin
                        in_pay_q <= 1'b1;
                        rem_q    <= wc;
                        first_q  <= 1'b1;
                        auto_q   <= (fst_q == FR_OPEN);
                    end
                end
            end else if (in_pay_q && body_vld) begin
                line_valid <= 1'b1;
                pix_byte   <= body_byte;
                first_q    <= 1'b0;
                rem_q      <= rem_q - WC_W'(1);
                if (first_q && auto_q) line_start <= 1'b1;
                if (rem_q == WC_W'(1)) begin
                    in_pay_q <= 1'b0;
                    if (auto_q) line_end <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/csi_packet_decoder.sv
// Top of the camera packet decoder: header capture, check, sequencer.
// Assumes aligned bytes with a start-of-packet marker on the identifier.
module csi_packet_decoder
    import csi_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_byte,
    output logic              frame_start,
    output logic              frame_end,
    output logic              line_start,
    output logic              line_end,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [7:0]        pix_byte,
    output logic [15:0]       word_count,
    output logic [7:0]        data_type,
    output logic              ecc_err
);
    logic              hdr_done;
    logic [HDR_W-1:0]  hdr_bits;
    logic [BYTE_W-1:0] ecc_rx;
    logic [ECC_W-1:0]  ecc_calc;
    logic              body_vld;
    logic [BYTE_W-1:0] body_byte;
    logic              ecc_ok;

    csi_hdr_capture i_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .hdr_done(hdr_done), .hdr_bits(hdr_bits),
        .ecc_rx(ecc_rx), .body_vld(body_vld), .body_byte(body_byte)
    );

    csi_ecc_gen i_ecc (.hdr_bits(hdr_bits), .ecc_calc(ecc_calc));

    // Received check byte must match, upper two bits zero.
    assign ecc_ok = (ecc_rx == {{(BYTE_W-ECC_W){1'b0}}, ecc_calc});

    csi_frame_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .hdr_bits(hdr_bits),
        .ecc_ok(ecc_ok), .body_vld(body_vld), .body_byte(body_byte),
        .frame_start(frame_start), .frame_end(frame_end),
        .line_start(line_start), .line_end(line_end),
        .frame_valid(frame_valid), .line_valid(line_valid),
        .pix_byte(pix_byte), .word_count(word_count),
        .data_type(data_type), .ecc_err(ecc_err)
    );
endmodule

// File: rtl/csi_dec_checker.sv
// Protocol checks on the decoder's outputs; bound to the top module.
module csi_dec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_start,
    input logic        frame_end,
    input logic        line_start,
    input logic        line_end,
    input logic        frame_valid,
    input logic        line_valid,
    input logic [15:0] word_count,
    input logic [7:0]  data_type,
    input logic        ecc_err
);
    assert_fs_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> frame_valid);
    assert_fe_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_valid);
    assert_fe_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> frame_valid);
    assert_ls_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> frame_valid);
    assert_lv_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);
    assert_err_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_err |-> !(frame_start || frame_end || line_start || line_end || line_valid));
    assert_err_keeps_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_err |-> ($stable(data_type) && $stable(word_count)));
    assert_hdr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, frame_end, ecc_err}));
endmodule

bind csi_packet_decoder csi_dec_checker i_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .line_start(line_start), .line_end(line_end), .frame_valid(frame_valid),
    .line_valid(line_valid), .word_count(word_count), .data_type(data_type),
    .ecc_err(ecc_err)
);

// File: tb/test_csi_packet_decoder.sv
`timescale 1ns/1ps
module test_csi_packet_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_byte = '0;
    logic fs, fe, ls, le, fv, lv, err;
    logic [7:0] pix, dtyp;
    logic [15:0] wcnt;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csi_packet_decoder i_csi_packet_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .frame_start(fs), .frame_end(fe), .line_start(ls),
        .line_end(le), .frame_valid(fv), .line_valid(lv), .pix_byte(pix),
        .word_count(wcnt), .data_type(dtyp), .ecc_err(err)
    );

    // R1 column codes: the check-bit set contributed by each header bit.
    localparam logic [5:0] COL [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    function automatic logic [7:0] calc_ecc(input logic [23:0] d);
        logic [5:0] e = '0;
        for (int i = 0; i < 24; i++) if (d[i]) e ^= COL[i];
        return {2'b00, e};
    endfunction

    // Row: id, wc, corrupt, expected {fs,fe,ls,le,err}, expected frame_valid.
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {8'h01, 16'h0000, 1'b0, 5'b00000, 1'b0},  // R5 frame end, no frame
        {8'h00, 16'h0001, 1'b0, 5'b10000, 1'b1},  // R3 frame start
        {8'h02, 16'h0000, 1'b0, 5'b00100, 1'b1},  // R6 line start
        {8'h02, 16'h0000, 1'b0, 5'b00000, 1'b1},  // R6 line already open
        {8'h03, 16'h0000, 1'b0, 5'b00010, 1'b1},  // R6 line end
        {8'h03, 16'h0000, 1'b0, 5'b00000, 1'b1},  // R6 no line open
        {8'h08, 16'h1234, 1'b0, 5'b00000, 1'b1},  // R12 generic short
        {8'h40, 16'h0002, 1'b0, 5'b10000, 1'b1},  // R10 channel bits set
        {8'h00, 16'h0003, 1'b1, 5'b00001, 1'b1},  // R2 corrupted check
        {8'hC1, 16'h0000, 1'b0, 5'b01000, 1'b1},  // R4 frame end, channel 3
        {8'h02, 16'h0000, 1'b0, 5'b00000, 1'b0},  // R6 outside frame
        {8'h03, 16'h0000, 1'b0, 5'b00000, 1'b0}   // R6 outside frame
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R5";
            1: return "R3";
            6: return "R12";
            7: return "R10";
            8: return "R2";
            9: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One accepted byte followed by an idle cycle; outputs then reflect it.
    task automatic xfer(input logic [7:0] b, input logic sop);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic send_hdr(input logic [7:0] id, input logic [15:0] wc, input bit bad);
        logic [7:0] e;
        e = calc_ecc({wc, id});
        if (bad) e ^= 8'h04;
        xfer(id, 1'b1);
        xfer(wc[7:0], 1'b0);
        xfer(wc[15:8], 1'b0);
        xfer(e, 1'b0);
    endtask

    function automatic logic [4:0] pulses();
        return {fs, fe, ls, le, err};
    endfunction

    // Long payload: checks line_valid, byte, and derived line pulses per byte.
    task automatic send_body(input int n, input logic [7:0] seed,
                             input bit expect_out, input bit auto_ln, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 7);
            xfer(b, 1'b0);
            chk(lv == expect_out, tag, 32'(lv), 32'(expect_out));
            if (expect_out) begin
                chk(pix == b, "R7", 32'(pix), 32'(b));
                chk(ls == (auto_ln && i == 0), "R8", 32'(ls), 32'(auto_ln && i == 0));
                chk(le == (auto_ln && i == n - 1), "R8", 32'(le), 32'(auto_ln && i == n - 1));
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  last_dt;
        logic [15:0] last_wc;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({fs, fe, ls, le, fv, lv, err} == 7'b0 && pix == 8'h00 && wcnt == 16'h0 && dtyp == 8'h00,
            "R11", {fs, fe, ls, le, fv, lv, err, pix, dtyp}, 32'h0);
        rst_n = 1'b1;
        last_dt = 8'h00; last_wc = 16'h0000;

        for (int i = 0; i < NV; i++) begin
            logic [7:0] id; logic [15:0] wc; logic bad; logic [4:0] ep; logic efv;
            {id, wc, bad, ep, efv} = VEC[i];
            send_hdr(id, wc, bad);
            chk(pulses() == ep, row_tag(i), 32'(pulses()), 32'(ep));
            chk(fv == efv, row_tag(i), 32'(fv), 32'(efv));
            if (!bad) begin last_dt = {2'b00, id[5:0]}; last_wc = wc; end
            chk(dtyp == last_dt && wcnt == last_wc, bad ? "R2" : "R10",
                {dtyp, 8'h00, wcnt}, {last_dt, 8'h00, last_wc});
            if (i == 9) begin
                @(negedge clk);  // R4 frame_valid drops the cycle after frame_end
                chk(fv == 1'b0, "R4", 32'(fv), 32'h0);
            end
        end

        // R8 long packet with no line open: derived line pulses
        send_hdr(8'h00, 16'h0005, 1'b0);
        chk(fs == 1'b1, "R3", 32'(fs), 32'h1);
        send_hdr(8'h2B, 16'h0005, 1'b0);
        chk(dtyp == 8'h2B && wcnt == 16'h0005 && pulses() == 5'b0, "R10",
            {dtyp, 8'h00, wcnt}, {8'h2B, 8'h00, 16'h0005});
        send_body(5, 8'h11, 1'b1, 1'b1, "R7");
        send_body(2, 8'hA0, 1'b0, 1'b0, "R7");  // checksum bytes swallowed

        // R8 explicit line: payload makes no line pulses
        send_hdr(8'h02, 16'h0000, 1'b0);
        chk(ls == 1'b1, "R6", 32'(ls), 32'h1);
        send_hdr(8'h2A, 16'h0003, 1'b0);
        send_body(3, 8'h55, 1'b1, 1'b0, "R7");
        send_body(2, 8'h3C, 1'b0, 1'b0, "R7");
        send_hdr(8'h03, 16'h0000, 1'b0);
        chk(le == 1'b1, "R6", 32'(le), 32'h1);

        // R2 corrupted long header inside a frame: body dropped
        send_hdr(8'h2B, 16'h0004, 1'b1);
        chk(err == 1'b1, "R2", 32'(err), 32'h1);
        chk(dtyp == 8'h03 && wcnt == 16'h0000, "R2", {dtyp, 8'h00, wcnt}, {8'h03, 24'h0});
        send_body(4, 8'h70, 1'b0, 1'b0, "R2");

        // R12 generic short keeps the frame open and no line open
        send_hdr(8'h0F, 16'h0000, 1'b0);
        chk(pulses() == 5'b0 && fv == 1'b1, "R12", {27'h0, pulses()}, 32'h0);
        send_hdr(8'h03, 16'h0000, 1'b0);
        chk(le == 1'b0, "R12", 32'(le), 32'h0);

        send_hdr(8'h01, 16'h0000, 1'b0);
        chk(fe == 1'b1, "R4", 32'(fe), 32'h1);

        // R9 long packet outside any frame
        send_hdr(8'h2B, 16'h0002, 1'b0);
        send_body(2, 8'h90, 1'b0, 1'b0, "R9");
        chk(fv == 1'b0, "R9", 32'(fv), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule